// File: doc/BRIEF.md
# Transparent Serial Transmitter with Idle Fill

This block serializes octets taken from a transmit FIFO onto one or two serial lanes, bit for bit, with no framing, bit stuffing or check sequence. One bit leaves per pulse of a transmit bit-clock enable. When the FIFO has nothing to give, the block fills the line with an idle octet. That octet is either all ones or a programmable idle byte.

The block runs in one of two timing modes. In free-running mode, octets follow back to back, starting on the first bit tick after the enable rises. In slotted mode, every octet starts on a bit tick that coincides with an external slot-start strobe. The first octet after the enable is fixed by rule: in free-running mode it is the idle octet, even if data is already waiting, and in slotted mode it is 0xFF. A transmitter reset loads the mode, idle select and idle byte, and raises both event pulses. A done pulse marks the FIFO running dry, and an empty pulse marks the line falling back to idle after data.

Top module: `xparent_tx`

## Requirements
- R1: While `rst` is high, or `tx_en` is low, both lanes read 1 from the next cycle on and `fifo_pop` stays 0.
- R2: With idle select latched at 0, an octet boundary that finds the FIFO empty sends 0xFF.
- R3: With idle select latched at 1, an octet boundary that finds the FIFO empty sends the latched idle byte, and does so again at every such boundary.
- R4: In free-running mode, the first octet after `tx_en` rises is the idle octet (0xFF or the idle byte), and the FIFO is not popped for it, even when `fifo_valid` is high.
- R5: In slotted mode, the first octet after `tx_en` rises is 0xFF, whatever the idle select.
- R6: In free-running mode, bits leave least significant first, and `msb_first` has no effect.
- R7: In slotted mode, `msb_first`=1 sends bit 7 first, and `msb_first`=0 sends bit 0 first.
- R8: In free-running mode, the first bit goes out on the first `bit_tick` after `tx_en` rises, and a new octet starts every 8 ticks after that.
- R9: In slotted mode, an octet starts only on a `bit_tick` with `slot_start` high. Between octets the lanes read 1, and a `slot_start` in the middle of an octet is ignored.
- R10: `lane_a` carries the serial bit when `lane_a_en`=1 and reads 1 otherwise. `lane_b` behaves the same way under `lane_b_en`.
- R11: `fifo_pop` is a one-cycle strobe, raised only in the cycle an octet boundary takes `fifo_data`. FIFO bytes go out in the order they were offered.
- R12: `done_pulse` rises for one cycle after `fifo_valid` falls while `tx_en` is high. `empty_pulse` rises for one cycle after an octet boundary sends an idle octet right after a data octet.
- R13: A `tx_reset` cycle raises both `done_pulse` and `empty_pulse` in the next cycle, and restarts the first-octet rule.
- R14: `slot_mode`, `idle_sel` and `idle_byte` are sampled only during `rst` or `tx_reset`. Changing them at other times has no effect on the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| tx_reset | input | 1 | Transmitter reset; latches configuration |
| bit_tick | input | 1 | Transmit bit-clock enable, one bit per pulse |
| slot_start | input | 1 | Marks the first bit tick of a time slot (slotted mode) |
| slot_mode | input | 1 | 1 = slotted, 0 = free-running (latched at reset) |
| msb_first | input | 1 | Bit order select for slotted mode |
| idle_sel | input | 1 | 1 = idle byte fill, 0 = all-ones fill (latched at reset) |
| idle_byte | input | 8 | Programmable idle octet (latched at reset) |
| lane_a_en | input | 1 | Drive serial data on lane A |
| lane_b_en | input | 1 | Drive serial data on lane B |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_valid | input | 1 | FIFO holds at least one byte |
| fifo_pop | output | 1 | One-cycle strobe consuming the head byte |
| lane_a | output | 1 | Serial lane A |
| lane_b | output | 1 | Serial lane B |
| done_pulse | output | 1 | FIFO-drained / reset event pulse |
| empty_pulse | output | 1 | Line-fell-to-idle / reset event pulse |

## Verification
The bench aims at the first octet after enable, with data already waiting. A design that popped the FIFO at once would send the data byte early and skip the idle octet, and in slotted mode it would send the idle byte where 0xFF belongs. The bench changes the idle byte without a reset, which catches a design that reads the configuration live. It also sends stray `slot_start` pulses mid-octet and in free-running mode, which catches a design that realigns on them and cuts an octet short. Back-to-back and gapped slots, both bit orders, single-cycle ticks and lane masking are each compared against a behavioural model on every cycle, so a misplaced pop strobe or an event pulse that is off by one cycle also shows up.

// File: rtl/xtx_pkg.sv
package xtx_pkg;

    localparam int unsigned XTX_OCT_W = 8;

    typedef logic [XTX_OCT_W-1:0] octet_t;

    typedef struct packed {
        logic   slotted;
        logic   idle_sel;
        octet_t idle_byte;
    } xtx_cfg_t;

    function automatic octet_t idle_octet(input xtx_cfg_t cfg);
        return cfg.idle_sel ? cfg.idle_byte : '1;
    endfunction

    function automatic octet_t flip_octet(input octet_t v);
        octet_t r;
        for (int i = 0; i < XTX_OCT_W; i++) begin
            r[i] = v[XTX_OCT_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/xtx_cfg_latch.sv
module xtx_cfg_latch
    import xtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tx_reset,
    input  xtx_cfg_t cfg_in,
    output xtx_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst || tx_reset) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/xtx_octet_pick.sv
module xtx_octet_pick
    import xtx_pkg::*;
(
    input  xtx_cfg_t cfg,
    input  logic     first_pend,
    input  logic     fifo_valid,
    input  octet_t   fifo_data,
    input  logic     msb_first,
    output octet_t   word,
    output logic     take_fifo
);
    octet_t raw;

    always_comb begin
        take_fifo = !first_pend && fifo_valid;
        if (first_pend) begin
            raw = cfg.slotted ? '1 : idle_octet(cfg);
        end else if (fifo_valid) begin
            raw = fifo_data;
        end else begin
            raw = idle_octet(cfg);
        end
        word = (cfg.slotted && msb_first) ? flip_octet(raw) : raw;
    end
endmodule

// File: rtl/xtx_shifter.sv
module xtx_shifter #(
    parameter int unsigned OCT_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             tick,
    input  logic             load,
    input  logic [OCT_W-1:0] word,
    output logic             out_bit,
    output logic             drained
);
    localparam int unsigned CNT_W = $clog2(OCT_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OCT_W - 1);

    logic [OCT_W-1:0] sh;
    logic [CNT_W-1:0] left;

    assign drained = (left == '0);

    always_ff @(posedge clk) begin
        if (clr) begin
            left    <= '0;
            sh      <= '1;
            out_bit <= 1'b1;
        end else if (load) begin
            out_bit <= word[0];
            sh      <= {1'b1, word[OCT_W-1:1]};
            left    <= LAST;
        end else if (tick) begin
            if (!drained) begin
                out_bit <= sh[0];
                sh      <= {1'b1, sh[OCT_W-1:1]};
                left    <= left - 1'b1;
            end else begin
                out_bit <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xtx_events.sv
module xtx_events (
    input  logic clk,
    input  logic rst,
    input  logic tx_reset,
    input  logic tx_en,
    input  logic fifo_valid,
    input  logic gap_evt,
    output logic done_pulse,
    output logic empty_pulse
);
    logic valid_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_d     <= 1'b0;
            done_pulse  <= 1'b0;
            empty_pulse <= 1'b0;
        end else begin
            valid_d     <= fifo_valid;
            done_pulse  <= tx_reset || (tx_en && valid_d && !fifo_valid);
            empty_pulse <= tx_reset || gap_evt;
        end
    end
endmodule

// File: rtl/xparent_tx.sv
module xparent_tx
    import xtx_pkg::*;
#(
    parameter int unsigned OCT_W = XTX_OCT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             tx_reset,
    input  logic             bit_tick,
    input  logic             slot_start,
    input  logic             slot_mode,
    input  logic             msb_first,
    input  logic             idle_sel,
    input  logic [OCT_W-1:0] idle_byte,
    input  logic             lane_a_en,
    input  logic             lane_b_en,
    input  logic [OCT_W-1:0] fifo_data,
    input  logic             fifo_valid,
    output logic             fifo_pop,
    output logic             lane_a,
    output logic             lane_b,
    output logic             done_pulse,
    output logic             empty_pulse
);
    xtx_cfg_t cfg_in, cfg;
    octet_t   word;
    logic     take_fifo, drained, out_bit;
    logic     first_pend, last_data;
    logic     clr, load, gap_evt;

    assign cfg_in = '{slotted: slot_mode, idle_sel: idle_sel, idle_byte: idle_byte};

    xtx_cfg_latch i_cfg (
        .clk(clk), .rst(rst), .tx_reset(tx_reset), .cfg_in(cfg_in), .cfg_q(cfg)
    );

    xtx_octet_pick i_pick (
        .cfg(cfg), .first_pend(first_pend), .fifo_valid(fifo_valid),
        .fifo_data(fifo_data), .msb_first(msb_first),
        .word(word), .take_fifo(take_fifo)
    );

    assign clr     = rst || tx_reset || !tx_en;
    assign load    = !clr && bit_tick && drained && (!cfg.slotted || slot_start);
    assign fifo_pop = load && take_fifo;
    assign gap_evt = load && !take_fifo && !first_pend && last_data;

    xtx_shifter #(.OCT_W(OCT_W)) i_shift (
        .clk(clk), .clr(clr), .tick(bit_tick), .load(load), .word(word),
        .out_bit(out_bit), .drained(drained)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            first_pend <= 1'b1;
            last_data  <= 1'b0;
        end else if (load) begin
            first_pend <= 1'b0;
            last_data  <= take_fifo;
        end
    end

    xtx_events i_evt (
        .clk(clk), .rst(rst), .tx_reset(tx_reset), .tx_en(tx_en),
        .fifo_valid(fifo_valid), .gap_evt(gap_evt),
        .done_pulse(done_pulse), .empty_pulse(empty_pulse)
    );

    assign lane_a = lane_a_en ? out_bit : 1'b1;
    assign lane_b = lane_b_en ? out_bit : 1'b1;
endmodule

// File: rtl/xtx_checker.sv
module xtx_checker (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_reset,
    input logic bit_tick,
    input logic lane_a_en,
    input logic lane_b_en,
    input logic fifo_valid,
    input logic fifo_pop,
    input logic lane_a,
    input logic lane_b,
    input logic done_pulse,
    input logic empty_pulse
);
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (lane_a && lane_b));

    a_r1_no_pop_when_off: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !fifo_pop);

    a_r10_lane_a_masked: assert property (@(posedge clk) disable iff (rst)
        !lane_a_en |-> lane_a);

    a_r10_lane_b_masked: assert property (@(posedge clk) disable iff (rst)
        !lane_b_en |-> lane_b);

    a_r11_pop_needs_tick: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (bit_tick && fifo_valid && !tx_reset));

    a_r11_single_pop: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    a_r13_reset_events: assert property (@(posedge clk) disable iff (rst)
        tx_reset |=> (done_pulse && empty_pulse));
endmodule

bind xparent_tx xtx_checker i_xtx_checker (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_reset(tx_reset), .bit_tick(bit_tick),
    .lane_a_en(lane_a_en), .lane_b_en(lane_b_en), .fifo_valid(fifo_valid),
    .fifo_pop(fifo_pop), .lane_a(lane_a), .lane_b(lane_b),
    .done_pulse(done_pulse), .empty_pulse(empty_pulse)
);

// File: tb/test_xparent_tx.sv
module test_xparent_tx;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, tx_en, tx_reset, bit_tick, slot_start, slot_mode, msb_first, idle_sel;
    logic [7:0] idle_byte, fifo_data;
    logic lane_a_en, lane_b_en, fifo_valid;
    logic fifo_pop, lane_a, lane_b, done_pulse, empty_pulse;

    xparent_tx i_xparent_tx (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_reset(tx_reset), .bit_tick(bit_tick),
        .slot_start(slot_start), .slot_mode(slot_mode), .msb_first(msb_first),
        .idle_sel(idle_sel), .idle_byte(idle_byte), .lane_a_en(lane_a_en),
        .lane_b_en(lane_b_en), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
        .fifo_pop(fifo_pop), .lane_a(lane_a), .lane_b(lane_b),
        .done_pulse(done_pulse), .empty_pulse(empty_pulse)
    );

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    // bench FIFO and tick generation
    logic [7:0] q[$];
    bit pend_pop;
    int cyc_no = 0, tick_no = 0, tick_period = 3, slot_period = 12, slot_ofs = 3;

    // behavioural reference model
    bit m_bits[$];
    bit m_out = 1, m_done = 0, m_empty = 0, m_first = 1, m_lastdata = 0, m_prevvalid = 0;
    bit m_slot = 0, m_isel = 0;
    logic [7:0] m_ibyte = 8'hFF;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_idle();
        return m_isel ? m_ibyte : 8'hFF;
    endfunction

    task automatic model_step();
        bit exp_pop;
        logic [7:0] b;
        bit msb;
        bit use_fifo;
        chk(lane_a == (lane_a_en ? m_out : 1'b1), cur_req, "lane_a", lane_a, lane_a_en ? m_out : 1);
        chk(lane_b == (lane_b_en ? m_out : 1'b1), cur_req, "lane_b", lane_b, lane_b_en ? m_out : 1);
        chk(done_pulse == m_done, cur_req, "done_pulse", done_pulse, m_done);
        chk(empty_pulse == m_empty, cur_req, "empty_pulse", empty_pulse, m_empty);
        exp_pop = !rst && !tx_reset && tx_en && bit_tick && (m_bits.size() == 0)
                  && (!m_slot || slot_start) && !m_first && fifo_valid;
        chk(fifo_pop == exp_pop, cur_req, "fifo_pop", fifo_pop, exp_pop);
        if (rst || tx_reset) begin
            m_slot = slot_mode; m_isel = idle_sel; m_ibyte = idle_byte;
            m_bits.delete(); m_out = 1; m_first = 1; m_lastdata = 0;
            m_done = tx_reset && !rst; m_empty = tx_reset && !rst;
            m_prevvalid = rst ? 1'b0 : fifo_valid;
        end else begin
            m_done = tx_en && m_prevvalid && !fifo_valid;
            m_prevvalid = fifo_valid;
            m_empty = 0;
            if (!tx_en) begin
                m_bits.delete(); m_out = 1; m_first = 1; m_lastdata = 0;
            end else if (bit_tick) begin
                if (m_bits.size() > 0) begin
                    m_out = m_bits.pop_front();
                end else if (!m_slot || slot_start) begin
                    use_fifo = !m_first && fifo_valid;
                    if (m_first) b = m_slot ? 8'hFF : m_idle();
                    else if (use_fifo) b = fifo_data;
                    else b = m_idle();
                    if (!m_first && !use_fifo && m_lastdata) m_empty = 1;
                    msb = m_slot && msb_first;
                    for (int i = 0; i < 8; i++) m_bits.push_back(b[msb ? 7 - i : i]);
                    m_out = m_bits.pop_front();
                    m_lastdata = use_fifo;
                    m_first = 0;
                end else begin
                    m_out = 1;
                end
            end
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            fifo_valid = (q.size() > 0);
            fifo_data  = fifo_valid ? q[0] : 8'h00;
            @(negedge clk);
            pend_pop = fifo_pop;
            model_step();
            @(posedge clk);
            #1;
            if (pend_pop && q.size() > 0) void'(q.pop_front());
            cyc_no++;
            bit_tick = ((cyc_no % tick_period) == 0);
            if (bit_tick) tick_no++;
            slot_start = bit_tick && ((tick_no % slot_period) == slot_ofs);
        end
    endtask

    task automatic pulse_reset();
        tx_reset = 1; cyc(1); tx_reset = 0;
    endtask

    initial begin
        rst = 1; tx_en = 0; tx_reset = 0; bit_tick = 0; slot_start = 0; slot_mode = 0;
        msb_first = 0; idle_sel = 0; idle_byte = 8'hFF; lane_a_en = 1; lane_b_en = 1;
        fifo_valid = 0; fifo_data = 0;
        cyc(4);
        rst = 0;
        @(negedge clk);
        chk(lane_a && lane_b && !fifo_pop && !done_pulse && !empty_pulse,
            "R1", "reset state", {lane_a, lane_b, fifo_pop, done_pulse, empty_pulse}, 5'b11000);
        @(posedge clk); #1;

        // disabled with data waiting
        cur_req = "R1"; q.push_back(8'hA5); q.push_back(8'h3C); cyc(20);
        cur_req = "R13"; pulse_reset(); cyc(2);
        // free-running, msb_first must be ignored
        cur_req = "R4 R6 R8"; tx_en = 1; msb_first = 1; cyc(26);
        cur_req = "R11 R6 R8"; cyc(48);
        cur_req = "R2 R12"; cyc(60);
        cur_req = "R11 R12"; q.push_back(8'h81); q.push_back(8'h7E); q.push_back(8'h00); cyc(120);
        // config change without reset
        cur_req = "R14"; idle_sel = 1; idle_byte = 8'h5A; slot_mode = 1; cyc(60);
        slot_mode = 0;
        cur_req = "R13"; tx_en = 0; cyc(3); pulse_reset(); cyc(1);
        cur_req = "R3 R4"; tx_en = 1; cyc(100);
        cur_req = "R3 R12"; q.push_back(8'h11); cyc(70);
        cur_req = "R10 R8"; tick_period = 1; lane_a_en = 0; cyc(40);
        lane_b_en = 0; cyc(20);
        lane_a_en = 1; q.push_back(8'hE7); cyc(40);
        // slotted, gapped slots, lsb first
        cur_req = "R5 R9"; tick_period = 3; tx_en = 0; slot_mode = 1; idle_sel = 0; msb_first = 0;
        slot_period = 12; slot_ofs = 3; cyc(2); pulse_reset();
        q.push_back(8'hC4); q.push_back(8'h29); tx_en = 1; cyc(150);
        cur_req = "R7 R11 R9"; q.push_back(8'h0F); cyc(120);
        cur_req = "R10 R9"; lane_b_en = 1; slot_period = 10; slot_ofs = 5; cyc(120);
        // slotted, back-to-back slots, msb first, idle byte selected
        cur_req = "R5 R7"; tx_en = 0; idle_sel = 1; idle_byte = 8'h96; msb_first = 1;
        slot_period = 8; slot_ofs = 0; cyc(2); pulse_reset();
        q.push_back(8'hF0); q.push_back(8'h35); tx_en = 1; cyc(150);
        cur_req = "R3 R9 R12"; cyc(100);
        cur_req = "R7 R11"; q.push_back(8'h01); q.push_back(8'h80); cyc(120);
        // back to free-running after reset
        cur_req = "R14 R4"; tx_en = 0; slot_mode = 0; idle_sel = 0; cyc(2); pulse_reset();
        q.push_back(8'h5C); tx_en = 1; cyc(80);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule